// File: doc/BRIEF.md
# Transmit Frame Push Sequencer

This block moves one outgoing Ethernet frame from a byte stream into the transmit queue of an external network controller that sits on a SPI link. A request gives the frame length. The block rounds that length up to a whole number of 32-bit words. It refuses the frame at once if the rounded size is above the limit. If the frame is within the limit, the block reads the controller's free-memory register over SPI until there is room for the frame plus its 4-byte header. It then sets the controller's data-window bit and streams the frame in a single write burst. The burst is a one-byte burst opcode, a 4-byte length header and the padded payload. Finally the block clears the window bit and sets the controller's enqueue bit.

Every control-bit change is a read-modify-write, so the other bits of those controller registers are kept. One completion pulse with a 2-bit result code closes each request. The result is sent, too big, or no room (the poll budget ran out).

Top module: `txp_push`

## Requirements
- R1: After reset, chip select is high, the serial clock is low, and busy and done are both low.
- R2: The padded length is the request length rounded up to a multiple of 4. If it exceeds MAX_LEN (default 1500), the block pulses done with result code 2 and never lowers chip select.
- R3: The free-space poll is a register read of address 0x78. Only bits [11:0] of the returned word count. The block moves on only when that field is at least the length plus 4. Otherwise it polls again.
- R4: If POLL_LIMIT polls in a row all find too little space, done pulses with result code 3. No further SPI traffic is issued: no window change and no burst.
- R5: Before the burst, the block reads address 0x82 and writes it back with bit 3 set. After the burst, it reads 0x82 again and writes it back with bit 3 clear. All other bits are preserved.
- R6: The burst is one chip-select window carrying these bytes: 0xC0, then 0x00, 0x00, length[7:0], length[15:8], then the padded payload. The payload is the stream bytes in order, followed by zero fill. Exactly `length` bytes are taken from the stream.
- R7: Chip select rises only when the byte shifter is idle and the serial clock is low. The serial clock rises only while chip select is low.
- R8: After the window is closed, the block reads address 0x80 and writes it back with bit 0 set. Then done pulses with result code 1. The transaction order is: polls, window open, burst, window close, enqueue.
- R9: The SPI link runs in mode 0, most significant bit first. A register access is 4 bytes long. Byte 0 is {op[1:0] (00 read, 01 write), byte enables (1100 when address bit 1 is set, else 0011), address[7:6]}. Byte 1 is {address[5:2], 4'b0000}. Bytes 2 and 3 carry the 16-bit data, low byte first.
- R10: A start request while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_start | input | 1 | Start pulse, sampled when not busy |
| req_len | input | LW | Frame length in bytes |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | Result: 1 sent, 2 too big, 3 no room |
| pl_valid | input | 1 | Payload byte available |
| pl_data | input | 8 | Payload byte |
| pl_ready | output | 1 | Payload byte taken this cycle |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Chip select, active low |

## Verification
The assertions check on every cycle that chip select only rises with the shifter idle and the clock low, and that the serial clock only runs inside a window. They also check that no window opens while idle, that payload is taken only inside a window, and that every completion carries a nonzero code. The bench's slave model is needed for the rest. It decodes each SPI transaction and checks the order of polls and read-modify-writes, the preserved register bits, the header and zero fill, the exact poll count at the timeout boundary, and the free-space comparison at exactly length+3 versus length+4.

// File: rtl/txp_pkg.sv
package txp_pkg;
  typedef enum logic [1:0] {
    TXS_NONE   = 2'd0,
    TXS_SENT   = 2'd1,
    TXS_TOOBIG = 2'd2,
    TXS_NOROOM = 2'd3
  } txs_e;

  // Order is the transaction order of one accepted frame.
  typedef enum logic [2:0] {
    OP_POLL   = 3'd0,
    OP_RDWIN0 = 3'd1,
    OP_SETWIN = 3'd2,
    OP_DMA    = 3'd3,
    OP_RDWIN1 = 3'd4,
    OP_CLRWIN = 3'd5,
    OP_RDQ    = 3'd6,
    OP_SETQ   = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    XS_OPEN = 2'd0,
    XS_SEND = 2'd1,
    XS_GAP  = 2'd2
  } xs_e;

  localparam logic [7:0]  A_FREE   = 8'h78;
  localparam logic [7:0]  A_WIN    = 8'h82;
  localparam logic [7:0]  A_ENQ    = 8'h80;
  localparam logic [7:0]  BURST_OP = 8'hC0;
  localparam logic [15:0] WIN_BIT  = 16'h0008;
  localparam logic [15:0] ENQ_BIT  = 16'h0001;
  localparam int          HDR_BYTES = 5;
endpackage

// File: rtl/txp_spi_byte.sv
module txp_spi_byte (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [7:0] din,
  input  logic       miso,
  output logic       busy,
  output logic       done,
  output logic [7:0] dout,
  output logic       sclk,
  output logic       mosi
);
  logic [7:0] sh_q;
  logic [2:0] bit_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      dout  <= '0;
      sclk  <= 1'b0;
      mosi  <= 1'b0;
      sh_q  <= '0;
      bit_q <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy  <= 1'b1;
          sh_q  <= din;
          mosi  <= din[7];
          bit_q <= '0;
          sclk  <= 1'b0;
        end
      end else if (!sclk) begin
        sclk <= 1'b1;
        dout <= {dout[6:0], miso};
      end else begin
        sclk <= 1'b0;
        if (bit_q == 3'd7) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          bit_q <= bit_q + 3'd1;
          sh_q  <= {sh_q[6:0], 1'b0};
          mosi  <= sh_q[6];
        end
      end
    end
  end
endmodule

// File: rtl/txp_len_gate.sv
module txp_len_gate #(
  parameter int LW      = 12,
  parameter int PW      = LW + 1,
  parameter int MAX_LEN = 1500
) (
  input  logic [LW-1:0] len_i,
  output logic [PW-1:0] padded_o,
  output logic          too_big_o
);
  assign padded_o  = (PW'(len_i) + PW'(3)) & ~PW'(3);
  assign too_big_o = padded_o > PW'(MAX_LEN);
endmodule

// File: rtl/txp_byte_mux.sv
module txp_byte_mux
  import txp_pkg::*;
#(
  parameter int LW = 12,
  parameter int CW = LW + 2
) (
  input  op_e           op_i,
  input  logic [CW-1:0] idx_i,
  input  logic [15:0]   rdata_i,
  input  logic [LW-1:0] len_i,
  output logic [7:0]    byte_o,
  output logic          from_stream_o,
  output logic          is_read_o
);
  logic [7:0]    addr;
  logic          wr;
  logic [15:0]   wdata;
  logic [3:0]    be;
  logic [CW-1:0] pidx;
  logic [15:0]   len16;

  always_comb begin
    addr  = A_ENQ;
    wr    = 1'b0;
    wdata = rdata_i;
    case (op_i)
      OP_POLL:   addr = A_FREE;
      OP_RDWIN0: addr = A_WIN;
      OP_RDWIN1: addr = A_WIN;
      OP_SETWIN: begin addr = A_WIN; wr = 1'b1; wdata = rdata_i | WIN_BIT;  end
      OP_CLRWIN: begin addr = A_WIN; wr = 1'b1; wdata = rdata_i & ~WIN_BIT; end
      OP_SETQ:   begin addr = A_ENQ; wr = 1'b1; wdata = rdata_i | ENQ_BIT;  end
      default:   addr = A_ENQ;
    endcase
    be        = addr[1] ? 4'b1100 : 4'b0011;
    is_read_o = (op_i != OP_DMA) && !wr;
    pidx      = idx_i - CW'(HDR_BYTES);
    len16     = 16'(len_i);
    from_stream_o = 1'b0;
    byte_o        = 8'h00;
    if (op_i == OP_DMA) begin
      if (idx_i == CW'(0))      byte_o = BURST_OP;
      else if (idx_i == CW'(3)) byte_o = len16[7:0];
      else if (idx_i == CW'(4)) byte_o = len16[15:8];
      else if (idx_i >= CW'(HDR_BYTES)) from_stream_o = pidx < CW'(len_i);
    end else begin
      case (idx_i)
        CW'(0):  byte_o = {1'b0, wr, be, addr[7:6]};
        CW'(1):  byte_o = {addr[5:2], 4'h0};
        CW'(2):  byte_o = wr ? wdata[7:0]  : 8'h00;
        default: byte_o = wr ? wdata[15:8] : 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/txp_push.sv
module txp_push
  import txp_pkg::*;
#(
  parameter int LW         = 12,
  parameter int MAX_LEN    = 1500,
  parameter int POLL_LIMIT = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_start,
  input  logic [LW-1:0] req_len,
  output logic          busy,
  output logic          done,
  output logic [1:0]    status,
  input  logic          pl_valid,
  input  logic [7:0]    pl_data,
  output logic          pl_ready,
  output logic          spi_sclk,
  output logic          spi_mosi,
  input  logic          spi_miso,
  output logic          spi_cs_n
);
  localparam int PW  = LW + 1;
  localparam int CW  = LW + 2;
  localparam int PCW = $clog2(POLL_LIMIT + 1);

  logic [LW-1:0]  len_q;
  logic [PW-1:0]  pad_q;
  op_e            op_q;
  xs_e            xs_q;
  logic [CW-1:0]  bidx_q, cur_q;
  logic [15:0]    rdata_q;
  logic [PCW-1:0] polls_q;

  logic [PW-1:0]  pad_w;
  logic           too_big;
  logic [7:0]     mux_byte, sh_rx;
  logic           from_stream, is_read;
  logic           sh_busy, sh_done, issue, avail;
  logic [CW-1:0]  nbytes;
  logic           room_ok;

  txp_len_gate #(.LW(LW), .PW(PW), .MAX_LEN(MAX_LEN)) u_gate (
    .len_i(req_len), .padded_o(pad_w), .too_big_o(too_big)
  );

  txp_byte_mux #(.LW(LW), .CW(CW)) u_mux (
    .op_i(op_q), .idx_i(bidx_q), .rdata_i(rdata_q), .len_i(len_q),
    .byte_o(mux_byte), .from_stream_o(from_stream), .is_read_o(is_read)
  );

  assign nbytes   = (op_q == OP_DMA) ? CW'(pad_q) + CW'(HDR_BYTES) : CW'(4);
  assign avail    = !from_stream || pl_valid;
  assign issue    = busy && (xs_q == XS_SEND) && !sh_busy && (bidx_q < nbytes) && avail;
  assign pl_ready = issue && from_stream;
  assign room_ok  = 16'(rdata_q[11:0]) >= (16'(len_q) + 16'd4);

  txp_spi_byte u_shift (
    .clk(clk), .rst(rst), .start(issue),
    .din(from_stream ? pl_data : mux_byte),
    .miso(spi_miso), .busy(sh_busy), .done(sh_done), .dout(sh_rx),
    .sclk(spi_sclk), .mosi(spi_mosi)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      status   <= TXS_NONE;
      spi_cs_n <= 1'b1;
      len_q    <= '0;
      pad_q    <= '0;
      op_q     <= OP_POLL;
      xs_q     <= XS_OPEN;
      bidx_q   <= '0;
      cur_q    <= '0;
      rdata_q  <= '0;
      polls_q  <= '0;
    end else begin
      done <= 1'b0;
      if (sh_done && is_read) begin
        if (cur_q == CW'(2)) rdata_q[7:0]  <= sh_rx;
        if (cur_q == CW'(3)) rdata_q[15:8] <= sh_rx;
      end
      if (!busy) begin
        if (req_start) begin
          if (too_big) begin
            done   <= 1'b1;
            status <= TXS_TOOBIG;
          end else begin
            busy    <= 1'b1;
            len_q   <= req_len;
            pad_q   <= pad_w;
            op_q    <= OP_POLL;
            polls_q <= '0;
            xs_q    <= XS_OPEN;
          end
        end
      end else begin
        case (xs_q)
          XS_OPEN: begin
            spi_cs_n <= 1'b0;
            bidx_q   <= '0;
            xs_q     <= XS_SEND;
          end
          XS_SEND: begin
            if (issue) begin
              bidx_q <= bidx_q + CW'(1);
              cur_q  <= bidx_q;
            end else if (bidx_q == nbytes && !sh_busy) begin
              spi_cs_n <= 1'b1;
              xs_q     <= XS_GAP;
            end
          end
          default: begin
            xs_q <= XS_OPEN;
            if (op_q == OP_POLL) begin
              if (room_ok) begin
                op_q <= OP_RDWIN0;
              end else if (polls_q == PCW'(POLL_LIMIT - 1)) begin
                busy   <= 1'b0;
                done   <= 1'b1;
                status <= TXS_NOROOM;
              end else begin
                polls_q <= polls_q + PCW'(1);
              end
            end else if (op_q == OP_SETQ) begin
              busy   <= 1'b0;
              done   <= 1'b1;
              status <= TXS_SENT;
            end else begin
              op_q <= op_e'(op_q + 3'd1);
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/txp_push_chk.sv
module txp_push_chk (
  input logic       clk,
  input logic       rst,
  input logic       busy,
  input logic       done,
  input logic [1:0] status,
  input logic       cs_n,
  input logic       sclk,
  input logic       pl_ready,
  input logic       sh_busy
);
  p_cs_rise_idle_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n) |-> (!sh_busy && !sclk));

  p_sclk_in_window_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(sclk) |-> !cs_n);

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !busy |-> cs_n);

  p_stream_in_window_r6: assert property (@(posedge clk) disable iff (rst)
    pl_ready |-> (!cs_n && busy));

  p_done_coded_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> (status != 2'd0));

  p_window_needs_busy_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |-> busy);
endmodule

bind txp_push txp_push_chk u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .status(status),
  .cs_n(spi_cs_n), .sclk(spi_sclk), .pl_ready(pl_ready), .sh_busy(sh_busy)
);

// File: tb/txp_push_bench.sv
module txp_push_bench;
  localparam int LW = 12;
  localparam int MAXL = 1500;
  localparam int PLIM = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_start = 1'b0;
  logic [LW-1:0] req_len = '0;
  logic busy, done, pl_ready, sclk, mosi, cs_n;
  logic [1:0] status;
  logic pl_valid = 1'b0;
  logic [7:0] pl_data = 8'h00;
  logic miso = 1'b0;

  always #4 clk = ~clk;

  txp_push #(.LW(LW), .MAX_LEN(MAXL), .POLL_LIMIT(PLIM)) u_txp_push (
    .clk(clk), .rst(rst), .req_start(req_start), .req_len(req_len),
    .busy(busy), .done(done), .status(status),
    .pl_valid(pl_valid), .pl_data(pl_data), .pl_ready(pl_ready),
    .spi_sclk(sclk), .spi_mosi(mosi), .spi_miso(miso), .spi_cs_n(cs_n)
  );

  int errors = 0;
  int checks = 0;

  // request context owned by the stimulus
  int sess = 0;
  logic [15:0] init82, init80, free_ok, free_bad;
  int ready_after = 0;
  int base = 0;
  bit stall_en = 1'b0;
  logic [7:0] pl_mem [0:1599];

  // slave model state
  logic [7:0] tb [0:1599];
  int nb = 0, bitc = 0, sess_seen = -1, polls_seen = 0, nlog = 0;
  int ntrans = 0, dma_count = 0, dma_n = 0, fmt_err = 0;
  bit rd_mode = 1'b0, win_at_dma = 1'b0;
  logic prev_cs = 1'b1;
  logic [7:0] sreg = 8'h00;
  logic [15:0] r80 = 16'h0, r82 = 16'h0, resp = 16'h0;
  logic [15:0] lg [0:63];
  logic [7:0] dbuf [0:1599];

  function automatic logic [7:0] dec_addr(input logic [7:0] b0, input logic [7:0] b1);
    return {b0[1:0], b1[7:4], 2'b00} | ((b0[5:2] == 4'b1100) ? 8'h02 : 8'h00);
  endfunction

  function automatic logic [15:0] reg_val(input logic [7:0] a);
    if (a == 8'h78) return (polls_seen >= ready_after) ? free_ok : free_bad;
    if (a == 8'h82) return r82;
    if (a == 8'h80) return r80;
    return 16'h0;
  endfunction

  always @(posedge sclk or negedge cs_n or posedge cs_n) begin
    if (cs_n !== prev_cs) begin
      if (cs_n === 1'b0) begin
        if (sess_seen != sess) begin
          r82 = init82; r80 = init80; polls_seen = 0; nlog = 0; sess_seen = sess;
        end
        nb = 0; bitc = 0; rd_mode = 1'b0;
      end else if (cs_n === 1'b1 && prev_cs === 1'b0 && nb > 0) begin
        ntrans++;
        if (tb[0][7:6] == 2'b11) begin
          for (int i = 0; i < nb; i++) dbuf[i] = tb[i];
          dma_n = nb; dma_count++; win_at_dma = r82[3];
          if (nlog < 64) lg[nlog] = 16'h0300;
          nlog++;
        end else begin
          logic [7:0] a;
          a = dec_addr(tb[0], tb[1]);
          if (nb != 4 || tb[1][3:0] != 4'h0 || tb[0][7] != 1'b0) fmt_err++;
          if (nlog < 64) lg[nlog] = {6'b0, tb[0][7:6], a};
          nlog++;
          if (tb[0][7:6] == 2'b01 && nb == 4) begin
            if (a == 8'h82) r82 = {tb[3], tb[2]};
            if (a == 8'h80) r80 = {tb[3], tb[2]};
          end
          if (tb[0][7:6] == 2'b00 && a == 8'h78) polls_seen++;
        end
      end
      prev_cs = cs_n;
    end else if (cs_n === 1'b0) begin
      sreg = {sreg[6:0], mosi};
      bitc++;
      if (bitc == 8) begin
        if (nb < 1600) tb[nb] = sreg;
        nb++; bitc = 0;
        if (nb == 2) begin
          rd_mode = (tb[0][7:6] == 2'b00);
          resp = reg_val(dec_addr(tb[0], tb[1]));
        end
      end
    end
  end

  always @(negedge sclk) begin
    if (cs_n === 1'b0 && rd_mode && nb >= 2) begin
      int k;
      logic [15:0] st;
      k = (nb - 2) * 8 + bitc;
      st = {resp[7:0], resp[15:8]};
      if (k < 16) miso = st[15-k];
    end
  end

  // payload source
  int pl_taken = 0;
  always @(posedge clk) if (pl_valid && pl_ready) pl_taken <= pl_taken + 1;
  always @(negedge clk) begin
    pl_valid <= stall_en ? (($urandom % 4) != 0) : 1'b1;
    pl_data  <= pl_mem[(pl_taken - base) % 1600];
  end

  int ndone = 0;
  logic [1:0] last_st = 2'd0;
  always @(negedge clk) if (done === 1'b1) begin ndone++; last_st = status; end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int padded(input int l);
    return (l + 3) & ~3;
  endfunction

  task automatic run_req(input int len, input int ra, input bit stall, input bit dup);
    int d0, t0, dc0, w, pad, exp;
    bit ok;
    base = pl_taken;
    for (int i = 0; i < 1600; i++) pl_mem[i] = 8'($urandom);
    init82 = 16'($urandom) & 16'hFFF7;
    init80 = 16'($urandom) & 16'hFFFE;
    ready_after = ra;
    free_ok  = {4'($urandom), 12'(len + 4)};
    free_bad = {4'($urandom), 12'(len + 3)};
    stall_en = stall;
    sess++;
    d0 = ndone; t0 = ntrans; dc0 = dma_count;
    @(negedge clk); req_start = 1'b1; req_len = LW'(len);
    @(negedge clk); req_start = 1'b0;
    if (dup) begin
      repeat (40) @(negedge clk);
      req_start = 1'b1; req_len = LW'(1);
      @(negedge clk); req_start = 1'b0;
    end
    w = 0;
    while (ndone == d0 && w < 40000) begin @(negedge clk); w++; end
    chk(w < 40000, "R2 watchdog", w, 40000);
    repeat (60) @(negedge clk);
    pad = padded(len);
    exp = (pad > MAXL) ? 2 : (ra >= PLIM) ? 3 : 1;
    chk(last_st == 2'(exp), "R2/R4/R8 status", last_st, exp);
    chk(ndone - d0 == 1, "R10 one completion", ndone - d0, 1);
    chk(busy == 1'b0 && cs_n == 1'b1, "R1 idle after", busy, 0);
    if (exp == 2) begin
      chk(ntrans == t0, "R2 no SPI on reject", ntrans - t0, 0);
    end else if (exp == 3) begin
      chk(polls_seen == PLIM && nlog == PLIM, "R4 poll count", nlog, PLIM);
      chk(dma_count == dc0, "R4 no burst", dma_count - dc0, 0);
      chk(r82 == init82, "R4 window untouched", r82, init82);
    end else begin
      chk(nlog == ra + 8, "R8 transaction count", nlog, ra + 8);
      ok = 1'b1;
      for (int i = 0; i <= ra; i++) if (lg[i] != 16'h0078) ok = 1'b0;
      chk(ok, "R3 polls of 0x78", ra, ra + 1);
      chk(lg[ra+1] == 16'h0082 && lg[ra+2] == 16'h0182 && lg[ra+3] == 16'h0300,
          "R5 window open order", lg[ra+2], 16'h0182);
      chk(lg[ra+4] == 16'h0082 && lg[ra+5] == 16'h0182 && lg[ra+6] == 16'h0080 &&
          lg[ra+7] == 16'h0180, "R8 close and enqueue order", lg[ra+7], 16'h0180);
      chk(win_at_dma == 1'b1, "R5 window set during burst", win_at_dma, 1);
      chk(r82 == init82, "R5 window cleared, bits kept", r82, init82);
      chk(r80 == (init80 | 16'h1), "R8 enqueue bit", r80, init80 | 16'h1);
      chk(dma_n == pad + 5, "R6 burst length", dma_n, pad + 5);
      ok = (dbuf[0] == 8'hC0) && (dbuf[1] == 8'h00) && (dbuf[2] == 8'h00) &&
           (dbuf[3] == 8'(len)) && (dbuf[4] == 8'(len >> 8));
      chk(ok, "R6 header bytes", dbuf[3], len & 255);
      ok = 1'b1;
      for (int i = 0; i < pad; i++) begin
        logic [7:0] e;
        e = (i < len) ? pl_mem[i] : 8'h00;
        if (dbuf[5+i] != e) ok = 1'b0;
      end
      chk(ok, "R6 payload and zero fill", ok, 1);
      chk(pl_taken - base == len, "R6 stream bytes taken", pl_taken - base, len);
      chk(fmt_err == 0, "R9 register frame format", fmt_err, 0);
      if (dup) chk(dma_count - dc0 == 1, "R10 start ignored while busy", dma_count - dc0, 1);
    end
  endtask

  initial begin
    void'($urandom(32'd20240607));
    repeat (3) @(negedge clk);
    chk(cs_n == 1'b1 && sclk == 1'b0 && busy == 1'b0 && done == 1'b0,
        "R1 reset state", {cs_n, sclk, busy, done}, 4'b1000);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk(cs_n == 1'b1 && busy == 1'b0, "R1 out of reset", busy, 0);
    run_req(1501, 0, 1'b0, 1'b0);
    run_req(4095, 0, 1'b0, 1'b0);
    run_req(1, 0, 1'b0, 1'b0);
    run_req(0, 0, 1'b0, 1'b0);
    run_req(3, 2, 1'b1, 1'b0);
    run_req(1500, 0, 1'b1, 1'b0);
    run_req(1497, 1, 1'b0, 1'b0);
    run_req(40, PLIM - 1, 1'b1, 1'b0);
    run_req(40, PLIM, 1'b0, 1'b0);
    run_req(64, 1, 1'b0, 1'b1);
    for (int n = 0; n < 8; n++)
      run_req(1 + int'($urandom % 300), int'($urandom % 4), 1'b1, 1'b0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule